// File: doc/BRIEF.md
# Packed FP4 Pair to Half-Precision Decoder

This block dequantizes packed 4-bit floating-point weights. Each input byte holds two elements, each with a sign bit, a two-bit exponent and a one-bit mantissa. The block turns both elements into IEEE 754 half-precision values in one operation and presents them side by side on a 32-bit output word.

Every 4-bit value has an exact half-precision form, so the block needs no rounding logic. It can never produce NaN or infinity. The nonzero value that has a zero exponent field (0.5) comes out as an ordinary normal half value.

A valid strobe travels with the data. With the default `REG_OUT = 1`, the result is registered and appears one clock after the input is accepted. With `REG_OUT = 0`, the decode is purely combinational.

Top module: `fp4x2_to_half`

## Requirements
- R1: Bits [3:0] of `in_pack` (the even-index element) decode into `out_half[15:0]`. Bits [7:4] (the odd-index element) decode into `out_half[31:16]`.
- R2: A nibble is laid out as {sign[3], exponent[2:1], mantissa[0]}. When the exponent field e is nonzero, the lane has exponent field e+14 and fraction bit 9 equal to the mantissa. Fraction bits [8:0] are zero. The decoded magnitudes are 1.0=0x3C00, 1.5=0x3E00, 2.0=0x4000, 3.0=0x4200, 4.0=0x4400 and 6.0=0x4600.
- R3: Exponent 0 with mantissa 1 decodes to 0.5, which is 0x3800 when positive and 0xB800 when negative.
- R4: Exponent 0 with mantissa 0 decodes to signed zero, which is 0x0000 or 0x8000.
- R5: Bit 15 of each lane equals the sign bit of its nibble.
- R6: No lane ever carries exponent field 0x1F, so no NaN or infinity appears on the output.
- R7: With `REG_OUT = 1`, `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high, and the decoded word appears in that same cycle.
- R8: While `rst` is high (synchronous, active high), `out_valid` and `out_half` are cleared to zero on each clock edge.
- R9: With `REG_OUT = 1`, a cycle with `in_valid` low leaves `out_half` unchanged, whatever value `in_pack` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_pack | input | 8 | Two packed 4-bit elements, even index in the low nibble |
| out_valid | output | 1 | Decoded word is valid |
| out_half | output | 32 | Two half-precision lanes, even element in the low half |

## Verification
In the default registered build, each byte driven with `in_valid` high is captured at the next rising edge. Both lanes and `out_valid` are then due in that same cycle. The bench drives inputs on falling edges and reads the result on the falling edge that follows the capturing edge, which is one cycle after the stimulus. One further falling edge later it checks that `out_valid` has dropped again. Hold checks present a new byte with `in_valid` low and read the output a full cycle later, when it must still show the earlier result.

// File: rtl/fp4h_pkg.sv
package fp4h_pkg;
  localparam int ELEM_W    = 4;
  localparam int HALF_W    = 16;
  localparam int HEXP_W    = 5;
  localparam int HFRAC_W   = 10;
  localparam int HBIAS     = 15;
  localparam int ELEM_BIAS = 1;

  typedef struct packed {
    logic       sign;
    logic [1:0] expo;
    logic       man;
  } fp4_t;

  typedef struct packed {
    logic               sign;
    logic [HEXP_W-1:0]  expo;
    logic [HFRAC_W-1:0] frac;
  } half_t;
endpackage

// File: rtl/fp4_lane_decode.sv
module fp4_lane_decode
  import fp4h_pkg::*;
(
  input  logic [ELEM_W-1:0] nib,
  output logic [HALF_W-1:0] half
);
  localparam logic [HEXP_W-1:0] EXP_OFS  = HEXP_W'(HBIAS - ELEM_BIAS);
  localparam logic [HEXP_W-1:0] EXP_HALF = HEXP_W'(HBIAS - 1);

  fp4_t  el;
  half_t h;

  assign el = fp4_t'(nib);

  always_comb begin
    h      = '0;
    h.sign = el.sign;
    if (el.expo != 2'd0) begin
      h.expo = HEXP_W'(el.expo) + EXP_OFS;
      h.frac = {el.man, {(HFRAC_W-1){1'b0}}};
    end else if (el.man) begin
      h.expo = EXP_HALF;
    end
    half = h;
  end
endmodule

// File: rtl/fp4x2_decode_core.sv
module fp4x2_decode_core
  import fp4h_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*ELEM_W-1:0] packed_in,
  output logic [LANES*HALF_W-1:0] halves
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp4_lane_decode u_lane (
      .nib  (packed_in[g*ELEM_W +: ELEM_W]),
      .half (halves[g*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/fp4x2_to_half.sv
module fp4x2_to_half
  import fp4h_pkg::*;
#(
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*ELEM_W-1:0] in_pack,
  output logic                    out_valid,
  output logic [LANES*HALF_W-1:0] out_half
);
  localparam int IN_W  = LANES * ELEM_W;
  localparam int OUT_W = LANES * HALF_W;

  logic [OUT_W-1:0] dec_word;

  fp4x2_decode_core #(.LANES(LANES)) u_core (
    .packed_in (in_pack),
    .halves    (dec_word)
  );

  if (REG_OUT) begin : g_reg
    logic             v_q;
    logic [OUT_W-1:0] d_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= in_valid;
        if (in_valid) d_q <= dec_word;
      end
    end

    assign out_valid = v_q;
    assign out_half  = d_q;

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_half));
    assert_sign_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_half[HALF_W-1] == $past(in_pack[ELEM_W-1])));
    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_pack[ELEM_W-2:0] == '0) |=> (out_half[HALF_W-2:0] == '0));
    assert_reset_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && out_half == '0));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_half  = dec_word;
  end

  for (genvar a = 0; a < LANES; a++) begin : g_chk
    assert_no_special_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_half[a*HALF_W+HFRAC_W +: HEXP_W] != '1));
    assert_low_frac_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_half[a*HALF_W +: HFRAC_W-1] == '0));
  end

  logic unused_w;
  assign unused_w = ^IN_W;
endmodule

// File: tb/tb_fp4x2_to_half.sv
module tb_fp4x2_to_half;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_pack = 8'h00;
  logic        out_valid;
  logic [31:0] out_half;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fp4x2_to_half dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pack(in_pack),
    .out_valid(out_valid), .out_half(out_half)
  );

  function automatic logic [15:0] ref_half(input logic [3:0] n);
    logic [15:0] mag;
    case (n[2:0])
      3'd0: mag = 16'h0000;
      3'd1: mag = 16'h3800;
      3'd2: mag = 16'h3C00;
      3'd3: mag = 16'h3E00;
      3'd4: mag = 16'h4000;
      3'd5: mag = 16'h4200;
      3'd6: mag = 16'h4400;
      default: mag = 16'h4600;
    endcase
    return {n[3], mag[14:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] n);
    if (n[2:1] != 2'd0) return "R2";
    if (n[0]) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_pack  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", {31'd0, out_valid}, 32'd1);
    check({tag_of(b[3:0]), "/R1 low"}, {16'd0, out_half[15:0]}, {16'd0, ref_half(b[3:0])});
    check({tag_of(b[7:4]), "/R1 high"}, {16'd0, out_half[31:16]}, {16'd0, ref_half(b[7:4])});
    check("R5", {30'd0, out_half[31], out_half[15]}, {30'd0, b[7], b[3]});
    check("R6", {31'd0, (out_half[14:10] == 5'h1F) || (out_half[30:26] == 5'h1F)}, 32'd0);
  endtask

  initial begin
    logic [31:0] held;
    logic [7:0]  rb;
    rb = 8'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check("R8 valid", {31'd0, out_valid}, 32'd0);
    check("R8 data", out_half, 32'd0);
    rst = 1'b0;

    // directed corners: signed zero, signed half, largest magnitudes
    apply_and_check(8'h80);
    apply_and_check(8'h08);
    apply_and_check(8'h19);
    apply_and_check(8'h9F);
    apply_and_check(8'hF7);

    // R1/R2/R3/R4: every byte value
    for (int i = 0; i < 256; i++) apply_and_check(8'(i));

    // R7: valid drops one cycle after a lone strobe
    @(negedge clk);
    check("R7 drop", {31'd0, out_valid}, 32'd0);

    // R9: in_valid low ignores new data
    held = out_half;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_pack  = 8'($urandom());
      @(negedge clk);
      check("R9 hold", out_half, held);
    end

    // random traffic
    for (int k = 0; k < 300; k++) begin
      rb = 8'($urandom());
      apply_and_check(rb);
    end

    // R8: reset mid-stream clears output
    apply_and_check(8'h7F);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 mid valid", {31'd0, out_valid}, 32'd0);
    check("R8 mid data", out_half, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule